// File: doc/BRIEF.md
# Permanent-Fault Injection Campaign Controller

This block runs fault-injection campaigns against a duplicated combinational unit, such as a pair of multiplier copies whose outputs are compared and voted. Each experiment follows a fixed sequence. A one-cycle scrub pulse removes any earlier fault, and one settle cycle follows. The controller then draws an operand pair, a node index, a target copy (0 or 1) and a stuck-at polarity, and presents them to the unit. After a random delay it asserts a fault-enable. That enable stays on until the next scrub pulse.

While the fault is active, the controller watches the unit's voted result for a programmable number of cycles. It compares that result with a golden product it computes from its own operands. It counts the faults it injected and the experiments in which the result differed from the golden product. In random mode the values come from a 32-bit maximal-length LFSR, and a campaign runs a programmed number of experiments. In sweep mode the controller steps through every operand pair, every node and both polarities exactly once. The target copy and the injection instant stay random in sweep mode.

The operand outputs form a one-way stream qualified by `op_valid`. The stream has no ready input and no back-pressure, because the unit under test is combinational and takes a new pair in any cycle. Operands, node, copy and polarity hold steady for as long as `op_valid` is high.

Top module: `fi_campaign_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `op_valid`, `fault_active`, `scrub`, `inj_count` and `err_count` are all 0.
- R2: A `start` while the controller is idle or done captures `sweep_mode`, `seed`, `exp_total` and `obs_len`, clears both counters and begins with a one-cycle scrub pulse. A `start` while `busy` is 1 is ignored, and the running campaign keeps its own experiment count.
- R3: `fault_node` is always in 0..NODE_CNT-1 while `op_valid` is 1. Out-of-range random draws are rejected and redrawn.
- R4: `fault_active` rises after 1 to INJ_WIN cycles in which `op_valid` is 1 and `fault_active` is 0.
- R5: While `fault_active` is 1, the operands, node, copy and polarity stay unchanged. The cycle after a scrub pulse, `fault_active` is 0.
- R6: Each fault is observed for max(`obs_len`,1) cycles, counting only cycles with `fault_active`=1 and `scrub`=0. The scrub pulse follows at once, and `fault_active` is still 1 during that scrub cycle.
- R7: `inj_count` rises by one in each cycle in which `fault_active` rises.
- R8: `err_count` counts the experiments in which `uut_result` differed from `op_a`*`op_b` in at least one observe cycle. Mismatches outside the observe cycles are ignored. The updated count is visible in the experiment's closing scrub cycle.
- R9: In random mode a campaign runs exactly `exp_total` experiments and then a final scrub. After that, `done` is 1 and `busy` is 0 until the next `start`. When `exp_total`=0, no fault is injected.
- R10: In sweep mode `exp_total` is ignored. Experiment k presents polarity k mod 2, node (k/2) mod NODE_CNT, `op_b` = (k/(2·NODE_CNT)) mod 2^OP_W, and `op_a` as the remaining high part. The sweep ends after 2·NODE_CNT·2^(2·OP_W) experiments.
- R11: Two campaigns with the same settings and seed draw identical sequences. A seed of 0 is replaced by a fixed non-zero value, so the campaign still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a campaign (ignored while busy) |
| sweep_mode | input | 1 | 1 = sweep every operand pair, node and polarity; 0 = random |
| seed | input | 32 | LFSR seed (0 is replaced) |
| exp_total | input | CNT_W | Number of experiments in random mode |
| obs_len | input | OBS_W | Observe cycles per fault (0 acts as 1) |
| uut_result | input | 2*OP_W | Voted result from the unit under test |
| op_valid | output | 1 | Operands and fault target are valid |
| op_a | output | OP_W | First operand |
| op_b | output | OP_W | Second operand |
| fault_node | output | NODE_W | Node index to corrupt |
| fault_copy | output | 1 | Redundant copy to corrupt |
| stuck_val | output | 1 | Stuck-at polarity |
| fault_active | output | 1 | Fault enable, held until scrub |
| scrub | output | 1 | One-cycle fault-clear pulse |
| busy | output | 1 | Campaign in progress |
| done | output | 1 | Campaign complete |
| inj_count | output | CNT_W | Faults injected in this campaign |
| err_count | output | CNT_W | Experiments with a wrong result |

## Verification
The bench drives a modelled unit whose result is corrupted only for certain polarity/node pairs. This separates experiments that must be counted as errors from those that must not. Random corruption injected outside the observe window shows whether the comparison window is bounded correctly. A reduced sweep configuration is checked against the exact nesting order of R10, and rerunning with the same seed confirms that random campaigns repeat exactly. Short, zero-length and randomly sized campaigns and observe windows, together with a start pulse issued mid-campaign, exercise the boundaries of R2, R6 and R9.

// File: rtl/fi_pkg.sv
package fi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SCRUB, ST_SETTLE, ST_DRAW, ST_APPLY, ST_OBSERVE, ST_DONE
  } fi_state_e;

  localparam logic [31:0] LFSR_MASK = 32'h8020_0003;
  localparam logic [31:0] SEED_ALT  = 32'hACE1_2357;

  function automatic logic [31:0] lfsr_step(input logic [31:0] s);
    return {1'b0, s[31:1]} ^ (s[0] ? LFSR_MASK : 32'h0);
  endfunction
endpackage

// File: rtl/fi_lfsr.sv
module fi_lfsr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] seed,
  input  logic        adv,
  output logic [31:0] word
);
  import fi_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word <= SEED_ALT;
    else if (load) word <= (seed == 32'h0) ? SEED_ALT : seed;
    else if (adv)  word <= lfsr_step(word);
  end
endmodule

// File: rtl/fi_sweep.sv
module fi_sweep #(
  parameter int OP_W     = 8,
  parameter int NODE_CNT = 193,
  parameter int NODE_W   = $clog2(NODE_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [OP_W-1:0]   sw_a,
  output logic [OP_W-1:0]   sw_b,
  output logic [NODE_W-1:0] sw_node,
  output logic              sw_pol,
  output logic              sw_last
);
  localparam logic [NODE_W-1:0] NODE_MAX = NODE_W'(NODE_CNT - 1);

  logic node_wrap;
  assign node_wrap = (sw_node == NODE_MAX);
  assign sw_last   = sw_pol && node_wrap && (&sw_b) && (&sw_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_a <= '0; sw_b <= '0; sw_node <= '0; sw_pol <= 1'b0;
    end else if (clr) begin
      sw_a <= '0; sw_b <= '0; sw_node <= '0; sw_pol <= 1'b0;
    end else if (adv) begin
      sw_pol <= ~sw_pol;
      if (sw_pol) begin
        if (node_wrap) begin
          sw_node <= '0;
          sw_b    <= sw_b + 1'b1;
          if (&sw_b) sw_a <= sw_a + 1'b1;
        end else begin
          sw_node <= sw_node + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fi_campaign_ctrl.sv
module fi_campaign_ctrl #(
  parameter int OP_W     = 8,
  parameter int NODE_CNT = 193,
  parameter int INJ_WIN  = 4,
  parameter int OBS_W    = 8,
  parameter int CNT_W    = 32,
  localparam int NODE_W  = $clog2(NODE_CNT),
  localparam int RES_W   = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sweep_mode,
  input  logic [31:0]       seed,
  input  logic [CNT_W-1:0]  exp_total,
  input  logic [OBS_W-1:0]  obs_len,
  input  logic [RES_W-1:0]  uut_result,
  output logic              op_valid,
  output logic [OP_W-1:0]   op_a,
  output logic [OP_W-1:0]   op_b,
  output logic [NODE_W-1:0] fault_node,
  output logic              fault_copy,
  output logic              stuck_val,
  output logic              fault_active,
  output logic              scrub,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  inj_count,
  output logic [CNT_W-1:0]  err_count
);
  import fi_pkg::*;

  localparam int WIN_W  = (INJ_WIN > 1) ? $clog2(INJ_WIN) : 1;
  localparam int BASE_A = NODE_W;
  localparam int BASE_B = NODE_W + OP_W;
  localparam int BIT_C  = NODE_W + 2 * OP_W;
  localparam int BIT_P  = BIT_C + 1;
  localparam int BASE_I = BIT_P + 1;

  fi_state_e state;
  logic             mode_q, finished, mis_q;
  logic [CNT_W-1:0] total_q, exp_cnt;
  logic [OBS_W-1:0] obs_q, obs_cnt;
  logic [WIN_W-1:0] wait_q;

  logic [31:0]       rnd;
  logic [OP_W-1:0]   sw_a, sw_b;
  logic [NODE_W-1:0] sw_node;
  logic              sw_pol, sw_last;

  logic              launch, last_obs, mis_now;
  logic [NODE_W-1:0] draw_node;
  logic [OP_W-1:0]   draw_a, draw_b;
  logic              draw_pol, node_ok;
  logic [RES_W-1:0]  golden;

  assign busy     = (state != ST_IDLE) && (state != ST_DONE);
  assign done     = (state == ST_DONE);
  assign scrub    = (state == ST_SCRUB);
  assign op_valid = (state == ST_APPLY) || (state == ST_OBSERVE);
  assign launch   = start && !busy;
  assign last_obs = (state == ST_OBSERVE) && (obs_cnt <= OBS_W'(1));

  fi_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(launch), .seed(seed), .adv(busy), .word(rnd)
  );

  fi_sweep #(.OP_W(OP_W), .NODE_CNT(NODE_CNT), .NODE_W(NODE_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .clr(launch), .adv(last_obs),
    .sw_a(sw_a), .sw_b(sw_b), .sw_node(sw_node), .sw_pol(sw_pol), .sw_last(sw_last)
  );

  generate
    if (INJ_WIN > 1) begin : g_win
      logic [WIN_W-1:0] rnd_inst;
      assign rnd_inst = rnd[BASE_I +: WIN_W];
    end else begin : g_win
      logic [WIN_W-1:0] rnd_inst;
      assign rnd_inst = '0;
    end
  endgenerate

  assign draw_node = mode_q ? sw_node : rnd[NODE_W-1:0];
  assign draw_a    = mode_q ? sw_a    : rnd[BASE_A +: OP_W];
  assign draw_b    = mode_q ? sw_b    : rnd[BASE_B +: OP_W];
  assign draw_pol  = mode_q ? sw_pol  : rnd[BIT_P];
  assign node_ok   = 32'(draw_node) < NODE_CNT;
  assign golden    = RES_W'(op_a) * RES_W'(op_b);
  assign mis_now   = (uut_result != golden);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      mode_q <= 1'b0; finished <= 1'b0; mis_q <= 1'b0;
      total_q <= '0; exp_cnt <= '0; obs_q <= '0; obs_cnt <= '0; wait_q <= '0;
      op_a <= '0; op_b <= '0; fault_node <= '0; fault_copy <= 1'b0; stuck_val <= 1'b0;
      fault_active <= 1'b0; inj_count <= '0; err_count <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: if (start) begin
          mode_q    <= sweep_mode;
          total_q   <= exp_total;
          obs_q     <= obs_len;
          exp_cnt   <= '0;
          inj_count <= '0;
          err_count <= '0;
          finished  <= !sweep_mode && (exp_total == '0);
          state     <= ST_SCRUB;
        end
        ST_SCRUB: begin
          fault_active <= 1'b0;
          state        <= finished ? ST_DONE : ST_SETTLE;
        end
        ST_SETTLE: state <= ST_DRAW;
        ST_DRAW: if (node_ok) begin
          op_a       <= draw_a;
          op_b       <= draw_b;
          fault_node <= draw_node;
          fault_copy <= rnd[BIT_C];
          stuck_val  <= draw_pol;
          wait_q     <= g_win.rnd_inst;
          state      <= ST_APPLY;
        end
        ST_APPLY: begin
          if (wait_q == '0) begin
            fault_active <= 1'b1;
            inj_count    <= inj_count + 1'b1;
            obs_cnt      <= obs_q;
            mis_q        <= 1'b0;
            state        <= ST_OBSERVE;
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        ST_OBSERVE: begin
          if (last_obs) begin
            if (mis_q || mis_now) err_count <= err_count + 1'b1;
            exp_cnt  <= exp_cnt + 1'b1;
            finished <= mode_q ? sw_last : ((exp_cnt + 1'b1) == total_q);
            state    <= ST_SCRUB;
          end else begin
            obs_cnt <= obs_cnt - 1'b1;
            mis_q   <= mis_q || mis_now;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fi_campaign_chk.sv
module fi_campaign_chk #(
  parameter int NODE_CNT = 193,
  parameter int NODE_W   = 8,
  parameter int CNT_W    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scrub,
  input logic              fault_active,
  input logic              op_valid,
  input logic [NODE_W-1:0] fault_node,
  input logic              fault_copy,
  input logic              stuck_val,
  input logic              busy,
  input logic              done,
  input logic [CNT_W-1:0]  inj_count
);
  AST_NODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (32'(fault_node) < NODE_CNT)); // R3
  AST_SCRUB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    scrub |=> !fault_active); // R5
  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_active && !scrub) |=> fault_active); // R5
  AST_TARGET_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_active && !scrub) |=> ($stable(fault_node) && $stable(fault_copy) && $stable(stuck_val))); // R5
  AST_INJ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_active) |-> (inj_count == $past(inj_count) + 1'b1)); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !op_valid && !fault_active)); // R9
endmodule

bind fi_campaign_ctrl fi_campaign_chk #(
  .NODE_CNT(NODE_CNT), .NODE_W(NODE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scrub(scrub), .fault_active(fault_active),
  .op_valid(op_valid), .fault_node(fault_node), .fault_copy(fault_copy),
  .stuck_val(stuck_val), .busy(busy), .done(done), .inj_count(inj_count)
);

// File: tb/tb_fi_campaign_ctrl.sv
module tb_fi_campaign_ctrl;
  localparam int OP_W = 2, NODE_CNT = 3, INJ_WIN = 4, OBS_W = 4, CNT_W = 16;
  localparam int NODE_W = $clog2(NODE_CNT);
  localparam int RES_W = 2 * OP_W;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sweep_mode = 1'b0;
  logic [31:0] seed = '0;
  logic [CNT_W-1:0] exp_total = '0;
  logic [OBS_W-1:0] obs_len = '0;
  logic [RES_W-1:0] uut_result;
  logic op_valid, fault_copy, stuck_val, fault_active, scrub, busy, done;
  logic [OP_W-1:0] op_a, op_b;
  logic [NODE_W-1:0] fault_node;
  logic [CNT_W-1:0] inj_count, err_count;
  logic noise = 1'b0, corrupt;

  always #2 clk = ~clk;

  fi_campaign_ctrl #(.OP_W(OP_W), .NODE_CNT(NODE_CNT), .INJ_WIN(INJ_WIN),
                     .OBS_W(OBS_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sweep_mode(sweep_mode), .seed(seed),
    .exp_total(exp_total), .obs_len(obs_len), .uut_result(uut_result),
    .op_valid(op_valid), .op_a(op_a), .op_b(op_b), .fault_node(fault_node),
    .fault_copy(fault_copy), .stuck_val(stuck_val), .fault_active(fault_active),
    .scrub(scrub), .busy(busy), .done(done), .inj_count(inj_count), .err_count(err_count)
  );

  function automatic logic [RES_W-1:0] prod(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b);
    return RES_W'(a) * RES_W'(b);
  endfunction

  assign corrupt = (fault_active && stuck_val && fault_node[0]) ||
                   (noise && op_valid && !fault_active);
  assign uut_result = prod(op_a, op_b) ^ RES_W'(corrupt);

  int n_checks = 0, n_errs = 0, cyc = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic p_ov, p_fa, p_scrub, flag, sweep_exp;
  int dly, obsc, exps, scrubs, exp_inj, exp_err, obs_eff;
  logic [OP_W-1:0] r_a, r_b;
  logic [NODE_W-1:0] r_node;
  logic r_copy, r_pol;
  int recbuf[32];
  int keep[32];

  always @(negedge clk) begin
    cyc++;
    noise = 1'($urandom);
    if (!rst_n) begin
      p_ov = 0; p_fa = 0; p_scrub = 0;
    end else begin
      if (p_scrub) chk(fault_active == 0, "R5 scrub clears", fault_active, 0);
      if (op_valid && !p_ov) begin
        r_a = op_a; r_b = op_b; r_node = fault_node; r_copy = fault_copy; r_pol = stuck_val;
        dly = 0;
        chk(int'(fault_node) < NODE_CNT, "R3 node range", fault_node, NODE_CNT - 1);
      end
      if (op_valid && !fault_active) dly++;
      if (fault_active && !p_fa) begin
        chk(dly >= 1 && dly <= INJ_WIN, "R4 inject delay", dly, INJ_WIN);
        exp_inj++;
        chk(int'(inj_count) == exp_inj, "R7 inj_count", inj_count, exp_inj);
        obsc = 0; flag = 0;
      end
      if (fault_active && !scrub) begin
        obsc++;
        chk(op_a == r_a && op_b == r_b && fault_node == r_node && fault_copy == r_copy &&
            stuck_val == r_pol, "R5 target stable", {op_a, op_b, fault_node}, {r_a, r_b, r_node});
        if (stuck_val && fault_node[0]) flag = 1;
      end
      if (scrub) scrubs++;
      if (scrub && fault_active) begin
        chk(obsc == obs_eff, "R6 observe length", obsc, obs_eff);
        if (flag) exp_err++;
        chk(int'(err_count) == exp_err, "R8 err_count", err_count, exp_err);
        if (sweep_exp) begin
          int k, en, eb, ea, ep;
          k = exps; ep = k % 2; en = (k / 2) % NODE_CNT;
          eb = (k / (2 * NODE_CNT)) % (1 << OP_W); ea = k / (2 * NODE_CNT * (1 << OP_W));
          chk(r_pol == ep && r_node == en && r_b == eb && r_a == ea, "R10 sweep order",
              {r_a, r_b, r_node, r_pol}, (ea << (OP_W + NODE_W + 1)) | (eb << (NODE_W + 1)) | (en << 1) | ep);
        end
        if (exps < 32) recbuf[exps] = {r_a, r_b, r_node, r_copy, r_pol};
        exps++;
      end
      p_ov = op_valid; p_fa = fault_active; p_scrub = scrub;
    end
    if (cyc > 150000) begin
      n_checks++; n_errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  task automatic launch(input logic [31:0] sd, input logic sw, input int tot, input int ob);
    exps = 0; scrubs = 0; exp_inj = 0; exp_err = 0;
    sweep_exp = sw; obs_eff = (ob == 0) ? 1 : ob;
    seed = sd; sweep_mode = sw; exp_total = CNT_W'(tot); obs_len = OBS_W'(ob);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_wait(input int want, input string req);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(exps == want, req, exps, want);
    chk(int'(inj_count) == want, req, inj_count, want);
    chk(done && !busy, "R9 done level", {done, busy}, 2);
  endtask

  task automatic run(input logic [31:0] sd, input logic sw, input int tot, input int ob,
                     input int want, input string req);
    launch(sd, sw, tot, ob);
    finish_wait(want, req);
  endtask

  initial begin
    sweep_exp = 0; obs_eff = 1; exps = 0; scrubs = 0; exp_inj = 0; exp_err = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !op_valid && !fault_active && !scrub, "R1 reset outputs",
        {busy, done, op_valid, fault_active, scrub}, 0);
    chk(inj_count == 0 && err_count == 0, "R1 reset counters", inj_count + err_count, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(32'h0001_2345, 1'b0, 20, 3, 20, "R9 random count");
    for (int i = 0; i < 20; i++) keep[i] = recbuf[i];
    run(32'h0001_2345, 1'b0, 20, 3, 20, "R11 rerun count");
    for (int i = 0; i < 20; i++) chk(keep[i] == recbuf[i], "R11 same sequence", recbuf[i], keep[i]);

    run(32'h0BAD_F00D, 1'b0, 8, 0, 8, "R6 obs zero count");

    launch(32'h77, 1'b0, 0, 2);
    finish_wait(0, "R9 zero experiments");
    chk(scrubs == 1, "R2 single scrub", scrubs, 1);

    run(32'h0, 1'b0, 5, 2, 5, "R11 zero seed");

    launch(32'h5151, 1'b0, 6, 2);
    repeat (12) @(negedge clk);
    exp_total = CNT_W'(2); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    finish_wait(6, "R2 start while busy ignored");

    run(32'hC0FFEE, 1'b1, 3, 1, 2 * NODE_CNT * (1 << (2 * OP_W)), "R10 sweep total");

    for (int i = 0; i < 6; i++) begin
      int t, o;
      t = 1 + int'($urandom % 10); o = int'($urandom % 6);
      run($urandom, 1'b0, t, o, t, "R9 random campaign");
    end

    $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
  end
endmodule